// File: doc/BRIEF.md
# USB Buffer Descriptor Index Generator

This block tells a USB serial interface engine which of 64 buffer descriptor slots belongs to the current transaction. Its inputs are an endpoint number from 0 to 15, a direction and a 2-bit buffering mode. From these, together with an even/odd ping-pong pointer that it keeps for each endpoint and direction, it forms a 6-bit descriptor index. It also forms the byte address of that descriptor. Each descriptor takes four bytes, so the address is a fixed base plus four times the index.

The index and address follow the inputs combinationally. When the engine finishes a transaction, it pulses a completion strobe. If the addressed endpoint and direction is double-buffered in the current mode, its pointer then flips, and the next transaction on that direction uses the other buffer. A synchronous reset returns every pointer to even, and so does any change of the buffering mode.

Top module: `usb_bd_index`

## Requirements
- R1: With mode 0, endpoint n OUT (dir=0) maps to index 2n and endpoint n IN (dir=1) maps to index 2n+1.
- R2: With mode 1, endpoint 0 IN maps to index 2. Endpoint 0 OUT maps to index 0 while its pointer is even and to index 1 while it is odd.
- R3: With mode 1 and n of 1 or more, endpoint n OUT maps to 2n+1 and endpoint n IN maps to 2n+2, so endpoint 15 IN gives 32. No mode-1 index exceeds 32.
- R4: With mode 2, endpoint n OUT maps to 4n (even) or 4n+1 (odd), and endpoint n IN maps to 4n+2 (even) or 4n+3 (odd).
- R5: Mode value 3 is reserved and maps exactly like mode 0.
- R6: A completion strobe on a double-buffered direction (mode 1 endpoint 0 OUT, or any direction in mode 2) flips that direction's pointer. The flip is visible from the next cycle.
- R7: A completion strobe changes no pointer other than the one it addresses. A strobe on a direction that is not double-buffered in the current mode has no effect.
- R8: While the synchronous reset is high, every pointer returns to even at the clock edge.
- R9: In the cycle where the mode differs from the previous cycle's mode, every pointer reads as even, all pointers are cleared at that edge, and any completion strobe in that cycle is dropped.
- R10: desc_addr equals DESC_BASE + 4 × desc_idx, modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Buffering mode: 0 none, 1 endpoint 0 OUT only, 2 all, 3 reserved |
| ep | input | 4 | Endpoint number |
| dir | input | 1 | 0 = OUT, 1 = IN |
| xfer_done | input | 1 | Transaction-complete strobe for ep/dir |
| desc_idx | output | 6 | Descriptor index 0..63 |
| desc_addr | output | ADDR_W | Descriptor byte address |

## Verification
Directed sequences go through every endpoint and direction in each of the four mode values, so that each mapping is pinned at its edges: endpoint 0, endpoint 1 and endpoint 15, where mode 1 lands on 32. Repeated strobes on mode-1 endpoint 0 OUT and on mode-2 directions show the even/odd alternation. Strobes aimed at a neighbouring direction, or at a direction that is not double-buffered, show that the pointers are independent. A strobe issued in the same cycle as a mode change, and strobes before a reset, show the clearing rules. A long random phase then mixes modes, endpoints and strobes against the bench's own model every cycle.

// File: rtl/usb_bd_index.sv
module usb_bd_index #(
  parameter int ADDR_W    = 12,
  parameter int DESC_BASE = 'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [3:0]        ep,
  input  logic              dir,
  input  logic              xfer_done,
  output logic [5:0]        desc_idx,
  output logic [ADDR_W-1:0] desc_addr
);
  logic [31:0] ptr_q;
  logic [1:0]  mode_q;
  logic [4:0]  slot;
  logic        mode_chg, pp, odd;

  assign slot     = {ep, dir};
  assign mode_chg = (mode != mode_q);
  assign pp       = (mode == 2'd2) || (mode == 2'd1 && ep == 4'd0 && !dir);
  assign odd      = !mode_chg && ptr_q[slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      mode_q <= mode;
    end else if (mode_chg) begin
      ptr_q  <= '0;
      mode_q <= mode;
    end else if (xfer_done && pp) begin
      ptr_q[slot] <= !ptr_q[slot];
    end
  end

  always_comb begin
    case (mode)
      2'd1:    desc_idx = (ep == 4'd0) ? (dir ? 6'd2 : {5'd0, odd})
                                       : {1'b0, ep, 1'b0} + 6'd1 + {5'd0, dir};
      2'd2:    desc_idx = {ep, dir, odd};
      default: desc_idx = {1'b0, ep, dir};
    endcase
  end

  assign desc_addr = ADDR_W'(DESC_BASE) + ADDR_W'({desc_idx, 2'b00});

  assert_reset_even_R8: assert property (@(posedge clk) rst |=> ptr_q == '0);
  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> ptr_q == '0);
  assert_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && pp && !mode_chg) |=> ptr_q[$past(slot)] != $past(ptr_q[slot]));
  assert_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !pp && !mode_chg) |=> $stable(ptr_q));
  assert_mode1_range_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |-> desc_idx <= 6'd32);
endmodule

// File: tb/usb_bd_index_bench.sv
module usb_bd_index_bench;
  localparam int AW = 12;
  localparam int BASE = 'h100;

  logic clk = 0, rst = 1, dir = 0, xfer_done = 0;
  logic [1:0] mode = 0;
  logic [3:0] ep = 0;
  logic [5:0] desc_idx;
  logic [AW-1:0] desc_addr;

  int total = 0, bad = 0;
  int ptr[32];
  int pmode = 0;
  bit finished = 0;

  usb_bd_index #(.ADDR_W(AW), .DESC_BASE(BASE)) u_usb_bd_index (
    .clk, .rst, .mode, .ep, .dir, .xfer_done, .desc_idx, .desc_addr);

  always #10 clk = ~clk;

  function automatic int model_idx(int m, int e, int d);
    int o;
    o = (m != pmode) ? 0 : ptr[e*2 + d];
    if (m == 1) begin
      if (e == 0) return d ? 2 : o;
      return 2*e + 1 + d;
    end
    if (m == 2) return 4*e + 2*d + o;
    return 2*e + d;
  endfunction

  task automatic step(int m, int e, int d, bit done, bit r, string req);
    int exp_i, exp_a;
    @(negedge clk);
    mode = m[1:0]; ep = e[3:0]; dir = d[0]; xfer_done = done; rst = r;
    #2;
    if (!r) begin
      exp_i = model_idx(m, e, d);
      exp_a = (BASE + 4*exp_i) % (1 << AW);
      total++;
      if (desc_idx != exp_i[5:0]) begin
        bad++;
        $display("FAIL %s idx mode=%0d ep=%0d dir=%0d got=%0d exp=%0d", req, m, e, d, desc_idx, exp_i);
      end
      total++;
      if (desc_addr != exp_a[AW-1:0]) begin
        bad++;
        $display("FAIL R10 addr got=%0h exp=%0h", desc_addr, exp_a);
      end
    end
    @(posedge clk);
    if (r || m != pmode) begin
      foreach (ptr[i]) ptr[i] = 0;
      pmode = m;
    end else if (done && (m == 2 || (m == 1 && e == 0 && d == 0)))
      ptr[e*2 + d] ^= 1;
  endtask

  initial begin
    step(2, 0, 0, 0, 1, "R8");
    step(2, 3, 0, 0, 1, "R8");
    step(2, 3, 0, 0, 0, "R8");            // reset state: 12, even
    for (int e = 0; e < 16; e++) begin
      step(0, e, 0, 1, 0, "R1");
      step(0, e, 1, 1, 0, "R1");
    end
    for (int e = 0; e < 16; e++) step(3, e, e & 1, 1, 0, "R5");
    step(1, 0, 0, 0, 0, "R9");
    step(1, 0, 0, 1, 0, "R2");            // 0, then flip
    step(1, 0, 0, 1, 0, "R6");            // 1
    step(1, 0, 0, 0, 0, "R6");            // back to 0
    step(1, 0, 1, 1, 0, "R7");            // IN not double-buffered
    step(1, 3, 0, 1, 0, "R7");
    step(1, 0, 0, 0, 0, "R7");            // still even
    for (int e = 1; e < 16; e++) begin
      step(1, e, 0, 1, 0, "R3");
      step(1, e, 1, 1, 0, "R3");
    end
    step(1, 0, 0, 1, 0, "R2");            // go odd
    step(1, 0, 0, 0, 0, "R2");            // 1
    step(2, 0, 0, 1, 0, "R9");            // change: reads even, strobe dropped
    step(2, 0, 0, 0, 0, "R9");            // still even
    for (int e = 0; e < 16; e++) begin
      step(2, e, 0, 1, 0, "R4");
      step(2, e, 0, 0, 0, "R6");
      step(2, e, 1, 0, 0, "R4");
    end
    step(2, 7, 1, 1, 0, "R6");
    step(2, 7, 0, 0, 0, "R7");            // neighbour untouched
    step(2, 7, 1, 0, 0, "R6");            // 31
    step(2, 7, 1, 0, 1, "R8");
    step(2, 7, 1, 0, 0, "R8");            // 30 after reset
    for (int k = 0; k < 3000; k++)
      step(($urandom % 23 == 0) ? $urandom % 4 : pmode, $urandom % 16, $urandom % 2,
           $urandom % 2, $urandom % 400 == 0, pmode == 1 ? "R3" : pmode == 2 ? "R4" : "R1");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule